// File: doc/BRIEF.md
# Multiplexed Row/Column Address Front End

This block serves the block-access mode of a memory that shares its serial data-in pins with a second mode. When block-access mode is selected, two of the shared pins act as active-low strobes, one for the row and one for the column. A group of address pins, ten wide by default, carries a row address while the row strobe is asserted and a column address while the column strobe is asserted. All pins are brought into the system clock through one common synchroniser, so the strobes and the address stay aligned. Strobe edges are found by comparing each synchronised sample with the one before it.

A falling row strobe starts a row cycle. It latches the row address and records which banks are to be written: a bank is selected when its active-low lane enable is low at that moment. The first falling column strobe inside the row cycle latches the start column. Each further falling column strobe in the same row cycle advances the column by one and wraps from the top address to zero. Every accepted column edge produces a one-clock access pulse. The same pulse appears on the write strobe of each bank selected for the row cycle. A rising row strobe ends the row cycle. When block-access mode is off, the strobes have no effect.

Top module: `mux_addr_front`

## Requirements
- R1: During and right after reset, `row_addr` and `col_addr` are 0, and `acc_pulse`, `wr_lo` and `wr_hi` are 0.
- R2: When `row_n` falls while `blk_mode` is 1, `row_addr` takes the value on `addr_pins` and holds it until the next accepted row fall.
- R3: The first accepted `col_n` fall in a row cycle loads `addr_pins` into `col_addr`.
- R4: Each later accepted `col_n` fall in the same row cycle sets `col_addr` to its previous value plus one, and 1023 wraps to 0.
- R5: A `col_n` fall outside a row cycle is ignored: there is no pulse and `col_addr` is unchanged.
- R6: `acc_pulse` is high for exactly one clock for each accepted `col_n` fall and is never high on two consecutive clocks.
- R7: `wr_lo` pulses together with `acc_pulse` exactly when `lane_lo_n` was 0 at the row fall that opened the current row cycle.
- R8: `wr_hi` pulses together with `acc_pulse` exactly when `lane_hi_n` was 0 at the row fall that opened the current row cycle.
- R9: A `row_n` rise ends the row cycle and clears both bank selections. A `col_n` fall seen in the same synchronised clock as the rise is ignored.
- R10: A `col_n` fall seen in the same synchronised clock as a `row_n` fall is ignored. The first column fall after that loads the start column.
- R11: While `blk_mode` is 0, strobe edges are ignored and any open row cycle is closed.
- R12: An accepted column fall shows on `acc_pulse` SYNC_STAGES+1 rising clock edges after the pin change, which is 3 edges with the defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_mode | input | 1 | 1 selects block-access use of the shared pins |
| row_n | input | 1 | Row strobe, active low |
| col_n | input | 1 | Column strobe, active low |
| addr_pins | input | ADDR_W | Shared row/column address pins |
| lane_lo_n | input | 1 | Lower bank lane enable, active low |
| lane_hi_n | input | 1 | Upper bank lane enable, active low |
| row_addr | output | ADDR_W | Latched row address |
| col_addr | output | ADDR_W | Current column address |
| acc_pulse | output | 1 | One-clock pulse for each accepted access |
| wr_lo | output | 1 | Lower bank write strobe |
| wr_hi | output | 1 | Upper bank write strobe |

## Verification
The row strobe and the column strobe can change state in the same synchronised clock. A column fall can then meet a row fall, which opens a cycle, or a row rise, which closes one. The bench provokes both cases by changing the two pins at the same clock edge in directed steps, and again at random in a long run of pin patterns. A reference model applies the rule that only an already-open, not-closing row cycle accepts a column edge, and each case is judged from the pulse count, the bank strobe counts and `col_addr`.

// File: rtl/mafe_pkg.sv
package mafe_pkg;
   // order of control bits inside the synchronised bundle (MSB first)
   localparam int CTL_W = 5;
   localparam int B_MODE = 4;
   localparam int B_ROW  = 3;
   localparam int B_COL  = 2;
   localparam int B_LO   = 1;
   localparam int B_HI   = 0;
   // idle level of the control bits: mode off, strobes and lanes inactive
   localparam logic [CTL_W-1:0] CTL_IDLE = 5'b0_1111;
endpackage

// File: rtl/mafe_sync.sv
module mafe_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 1) begin : g_bad_stages
      $error("mafe_sync: STAGES must be at least 1");
   end

   logic [W-1:0] pipe [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) pipe[0] <= RST_VAL;
            else        pipe[0] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) pipe[i] <= RST_VAL;
            else        pipe[i] <= pipe[i-1];
      end
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/mafe_edge.sv
module mafe_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic s,
   output logic fall,
   output logic rise
);
   logic prev;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev <= 1'b1;
      else        prev <= s;

   assign fall = prev & ~s;
   assign rise = ~prev & s;
endmodule

// File: rtl/mafe_col_ctr.sv
module mafe_col_ctr #(
   parameter int AW      = 10,
   parameter bit ADVANCE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          step,
   input  logic [AW-1:0] din,
   output logic [AW-1:0] col
);
   logic [AW-1:0] col_q;

   if (ADVANCE) begin : g_advance
      // later accesses walk forward, wrapping at the top address
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n)    col_q <= '0;
         else if (load) col_q <= din;
         else if (step) col_q <= col_q + AW'(1);
   end else begin : g_restart
      // later accesses restart from the latched start column
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n)    col_q <= '0;
         else if (load) col_q <= din;
   end

   assign col = col_q;
endmodule

// File: rtl/mux_addr_front.sv
module mux_addr_front
   import mafe_pkg::*;
#(
   parameter int ADDR_W      = 10,
   parameter int SYNC_STAGES = 2,
   parameter bit COL_ADVANCE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              blk_mode,
   input  logic              row_n,
   input  logic              col_n,
   input  logic [ADDR_W-1:0] addr_pins,
   input  logic              lane_lo_n,
   input  logic              lane_hi_n,
   output logic [ADDR_W-1:0] row_addr,
   output logic [ADDR_W-1:0] col_addr,
   output logic              acc_pulse,
   output logic              wr_lo,
   output logic              wr_hi
);
   localparam int BUS_W = CTL_W + ADDR_W;
   localparam logic [BUS_W-1:0] BUS_IDLE = {CTL_IDLE, {ADDR_W{1'b0}}};

   if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_aw
      $error("mux_addr_front: ADDR_W out of range");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("mux_addr_front: SYNC_STAGES must be at least 1");
   end

   logic [BUS_W-1:0]  bus_s;
   logic [CTL_W-1:0]  ctl_s;
   logic [ADDR_W-1:0] adr_s;

   mafe_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(BUS_IDLE)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({blk_mode, row_n, col_n, lane_lo_n, lane_hi_n, addr_pins}),
      .q     (bus_s)
   );

   assign ctl_s = bus_s[BUS_W-1:ADDR_W];
   assign adr_s = bus_s[ADDR_W-1:0];

   logic row_fall, row_rise, col_fall, col_rise_unused;

   mafe_edge u_row_edge (
      .clk (clk), .rst_n (rst_n), .s (ctl_s[B_ROW]),
      .fall (row_fall), .rise (row_rise)
   );
   mafe_edge u_col_edge (
      .clk (clk), .rst_n (rst_n), .s (ctl_s[B_COL]),
      .fall (col_fall), .rise (col_rise_unused)
   );

   logic mode_s;
   logic row_active, col_seen, sel_lo, sel_hi;
   logic accept;
   logic [ADDR_W-1:0] row_q;

   assign mode_s = ctl_s[B_MODE];
   // only an open row cycle that is not closing in this clock takes a column edge
   assign accept = mode_s & col_fall & row_active & ~row_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_active <= 1'b0;
         col_seen   <= 1'b0;
         sel_lo     <= 1'b0;
         sel_hi     <= 1'b0;
         row_q      <= '0;
      end else if (!mode_s) begin
         row_active <= 1'b0;
         col_seen   <= 1'b0;
         sel_lo     <= 1'b0;
         sel_hi     <= 1'b0;
      end else begin
         if (row_fall) begin
            row_q      <= adr_s;
            row_active <= 1'b1;
            col_seen   <= 1'b0;
            sel_lo     <= ~ctl_s[B_LO];
            sel_hi     <= ~ctl_s[B_HI];
         end else if (row_rise) begin
            row_active <= 1'b0;
            sel_lo     <= 1'b0;
            sel_hi     <= 1'b0;
         end
         if (accept) col_seen <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_pulse <= 1'b0;
         wr_lo     <= 1'b0;
         wr_hi     <= 1'b0;
      end else begin
         acc_pulse <= accept;
         wr_lo     <= accept & sel_lo;
         wr_hi     <= accept & sel_hi;
      end
   end

   mafe_col_ctr #(.AW(ADDR_W), .ADVANCE(COL_ADVANCE)) u_col (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (accept & ~col_seen),
      .step  (accept & col_seen),
      .din   (adr_s),
      .col   (col_addr)
   );

   assign row_addr = row_q;
endmodule

// File: rtl/mux_addr_front_chk.sv
module mux_addr_front_chk #(
   parameter int AW   = 10,
   parameter int SYNC = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          blk_mode,
   input logic          acc_pulse,
   input logic          wr_lo,
   input logic          wr_hi,
   input logic [AW-1:0] col_addr,
   input logic [AW-1:0] row_addr
);
   // cycles blk_mode has been low, saturating above the pipeline depth
   localparam int CW = $clog2(SYNC + 3) + 1;
   logic [CW-1:0] off_cnt;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                    off_cnt <= '0;
      else if (blk_mode)             off_cnt <= '0;
      else if (off_cnt <= CW'(SYNC)) off_cnt <= off_cnt + CW'(1);

   // R6: one clock wide
   a_r6_pulse_one_clk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_pulse |=> !acc_pulse);

   // R7: lower bank strobe only with an access
   a_r7_lo_with_access: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo |-> acc_pulse);

   // R8: upper bank strobe only with an access
   a_r8_hi_with_access: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hi |-> acc_pulse);

   // R4: the column moves only on an accepted access
   a_r4_col_moves_on_access: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_pulse |-> $stable(col_addr));

   // R11: no access once mode-off has crossed the pipeline
   a_r11_mode_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (off_cnt > CW'(SYNC)) |-> !acc_pulse);

   // R1: reset values
   always_ff @(posedge clk)
      if (!rst_n) begin
         a_r1_reset_vals: assert (!acc_pulse && !wr_lo && !wr_hi &&
                                  col_addr == '0 && row_addr == '0);
      end
endmodule

bind mux_addr_front mux_addr_front_chk #(.AW(ADDR_W), .SYNC(SYNC_STAGES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .blk_mode  (blk_mode),
   .acc_pulse (acc_pulse),
   .wr_lo     (wr_lo),
   .wr_hi     (wr_hi),
   .col_addr  (col_addr),
   .row_addr  (row_addr)
);

// File: tb/test_mux_addr_front.sv
module test_mux_addr_front;
   localparam int AW = 10;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n;
   logic          blk_mode, row_n, col_n, lane_lo_n, lane_hi_n;
   logic [AW-1:0] addr_pins;
   logic [AW-1:0] row_addr, col_addr;
   logic          acc_pulse, wr_lo, wr_hi;

   mux_addr_front #(.ADDR_W(AW), .SYNC_STAGES(2)) i_mux_addr_front (
      .clk (clk), .rst_n (rst_n), .blk_mode (blk_mode),
      .row_n (row_n), .col_n (col_n), .addr_pins (addr_pins),
      .lane_lo_n (lane_lo_n), .lane_hi_n (lane_hi_n),
      .row_addr (row_addr), .col_addr (col_addr),
      .acc_pulse (acc_pulse), .wr_lo (wr_lo), .wr_hi (wr_hi)
   );

   int errs = 0, checks = 0;
   int n_acc = 0, n_lo = 0, n_hi = 0;
   logic prev_acc = 1'b0;
   bit   done = 1'b0;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // pulse monitor, R6
   always @(negedge clk) begin
      if (rst_n) begin
         if (acc_pulse) n_acc++;
         if (wr_lo)     n_lo++;
         if (wr_hi)     n_hi++;
         if (acc_pulse && prev_acc) chk("R6 pulse wider than one clock", 1, 0);
         prev_acc = acc_pulse;
      end
   end

   // reference model
   logic [AW-1:0] m_row = '0, m_col = '0;
   logic m_act = 0, m_seen = 0, m_slo = 0, m_shi = 0;
   logic p_row = 1, p_col = 1;

   function automatic logic [AW-1:0] next_col(input logic [AW-1:0] c);
      return (c == AW'((1 << AW) - 1)) ? '0 : c + AW'(1);
   endfunction

   function automatic logic col_taken(input logic m, cf, act, rr);
      return m & cf & act & ~rr;
   endfunction

   task automatic step(input logic m, r, c, input logic [AW-1:0] a,
                       input logic lo, hi, input string tag, input bit lat = 0);
      logic rf, rr, cf, acc, e_lo, e_hi;
      int a0, l0, h0;
      @(negedge clk);
      rf = p_row & ~r;
      rr = ~p_row & r;
      cf = p_col & ~c;
      acc  = col_taken(m, cf, m_act, rr);
      e_lo = acc & m_slo;
      e_hi = acc & m_shi;
      if (!m) begin
         m_act = 0; m_seen = 0; m_slo = 0; m_shi = 0;
      end else begin
         if (rf) begin
            m_row = a; m_act = 1; m_seen = 0; m_slo = ~lo; m_shi = ~hi;
         end else if (rr) begin
            m_act = 0; m_slo = 0; m_shi = 0;
         end
         if (acc) begin
            m_col  = m_seen ? next_col(m_col) : a;
            m_seen = 1;
         end
      end
      a0 = n_acc; l0 = n_lo; h0 = n_hi;
      blk_mode = m; row_n = r; col_n = c; addr_pins = a;
      lane_lo_n = lo; lane_hi_n = hi;
      p_row = r; p_col = c;
      if (lat) begin
         repeat (2) @(negedge clk);
         chk({tag, " R12 early"}, acc_pulse, 0);
         @(negedge clk);
         chk({tag, " R12 on time"}, acc_pulse, acc);
         repeat (3) @(negedge clk);
      end else begin
         repeat (6) @(negedge clk);
      end
      chk({tag, " R6 pulses"}, n_acc - a0, acc);
      chk({tag, " R7 wr_lo"},  n_lo - l0,  e_lo);
      chk({tag, " R8 wr_hi"},  n_hi - h0,  e_hi);
      chk({tag, " R2 row_addr"}, row_addr, m_row);
      chk({tag, " R3/R4 col_addr"}, col_addr, m_col);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         chk("watchdog expired", 1, 0);
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 0; blk_mode = 0; row_n = 1; col_n = 1;
      addr_pins = '0; lane_lo_n = 1; lane_hi_n = 1;
      repeat (3) @(negedge clk);
      chk("R1 reset row_addr", row_addr, 0);
      chk("R1 reset col_addr", col_addr, 0);
      chk("R1 reset pulses", {acc_pulse, wr_lo, wr_hi}, 0);
      rst_n = 1;
      @(negedge clk);
      chk("R1 after reset", {acc_pulse, wr_lo, wr_hi}, 0);

      step(1, 1, 1, 10'h000, 1, 1, "idle");
      // R5: column fall with no row cycle
      step(1, 1, 0, 10'h2AA, 1, 1, "R5 col without row");
      step(1, 1, 1, 10'h000, 1, 1, "R5 col release");
      // R2 and R7: open row, lower bank only
      step(1, 0, 1, 10'h155, 0, 1, "R2 row fall");
      // R3 and R12: first column, latency checked
      step(1, 0, 0, 10'h3FE, 1, 1, "R3 first col", 1);
      step(1, 0, 1, 10'h000, 1, 1, "R4 col up");
      step(1, 0, 0, 10'h011, 1, 1, "R4 step to 1023");
      step(1, 0, 1, 10'h000, 1, 1, "R4 col up");
      step(1, 0, 0, 10'h022, 1, 1, "R4 wrap to 0");
      step(1, 0, 1, 10'h000, 1, 1, "R4 col up");
      // R9: column fall in the same clock as row rise
      step(1, 1, 0, 10'h0F0, 1, 1, "R9 rise with col fall");
      step(1, 1, 1, 10'h000, 1, 1, "R9 release");
      // R10: column fall with row fall, upper bank
      step(1, 0, 0, 10'h1C3, 1, 0, "R10 row and col fall");
      step(1, 0, 1, 10'h000, 1, 1, "R10 col up");
      step(1, 0, 0, 10'h07B, 1, 1, "R10 first col after");
      step(1, 0, 1, 10'h000, 1, 1, "R8 col up");
      step(1, 0, 0, 10'h000, 1, 1, "R8 second col");
      // R11: mode off closes the row cycle, edges ignored
      step(0, 0, 1, 10'h000, 1, 1, "R11 mode off");
      step(0, 0, 0, 10'h123, 1, 1, "R11 col ignored");
      step(0, 1, 1, 10'h000, 1, 1, "R11 release");
      step(0, 0, 1, 10'h321, 0, 0, "R11 row ignored");
      step(1, 0, 1, 10'h000, 1, 1, "R11 mode back");
      step(1, 0, 0, 10'h0AB, 1, 1, "R11 col after mode back");
      step(1, 1, 1, 10'h000, 1, 1, "R9 close");

      // constrained random patterns
      for (int i = 0; i < 500; i++) begin
         logic m, r, c;
         m = ($urandom % 20) != 0;
         r = (($urandom % 10) < 3) ? ~p_row : p_row;
         c = (($urandom % 2) == 0) ? ~p_col : p_col;
         step(m, r, c, AW'($urandom), 1'($urandom), 1'($urandom),
              "random R2/R3/R4/R9/R10");
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule